// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that follows a chain of descriptors in memory and sends the data each descriptor points to as a word stream. Every descriptor takes four consecutive words. The first word is the link to the next descriptor, and a zero link ends the chain. The second word is the data address. The third word holds the word count and the frame markers. The channel writes the fourth word back with a done flag once the descriptor is finished. A frame may span several descriptors: the start marker goes out with the first word of a descriptor flagged as frame start, and the end marker goes out with the last word of a descriptor flagged as frame end.

Software controls the channel through four registers. It can start the channel, ask it to park, and tell whether it is parked and safe to edit. It can read and, while the channel is parked, rewrite the held next-descriptor pointer. On restart the channel does not fetch its current descriptor again. It continues from the held pointer. A reload command lets software append a descriptor after the chain has ended: the channel re-reads the link word of the last descriptor it finished. A sticky interrupt marks the end of the chain.

Top module: `lldma_chan`

## Requirements
- R1: After reset, status (register 1) reads 1 (bit 0 safe set, bit 1 irq clear, bit 2 disable-pending clear), the next-pointer register (2) reads 0, irq is low and st_valid is low.
- R2: Writing register 0 with bit 0 (activate) set while the channel is parked and the next pointer is non-zero makes the channel fetch the descriptor at that pointer. Word +0 is the link, +1 the data address, and +2 the control word, with bit 31 frame-start, bit 30 frame-end and bits 15:0 the word count. The channel then streams that many memory words from the data address, in ascending order.
- R3: st_sof is high only with the first word of a frame-start descriptor, and st_eof is high only with the last word of a frame-end descriptor.
- R4: When a descriptor finishes, the channel writes word +3 with bit 31 set and bits 15:0 equal to the word count.
- R5: A zero link stops the channel after the current descriptor. irq then rises and stays high until register 1 is written with bit 1 set.
- R6: Writing register 0 with bit 1 (disable) set while the channel runs lets the current descriptor finish in full. The channel then parks with safe set and no irq, and register 2 reads the address of the next descriptor, which has not been fetched.
- R7: Writing activate while a disable is pending cancels the disable, and the chain runs to its end.
- R8: A restart continues from register 2, so a value written there while parked redirects the chain and the skipped descriptor's status word stays untouched.
- R9: Writes to register 2 while the channel is not parked have no effect.
- R10: Writing register 0 with bit 2 (reload) set while parked re-reads the link word of the last finished descriptor. If that link is non-zero, the chain continues from it.
- R11: A descriptor with a word count of 0 emits no stream words and still receives its status write.
- R12: Activate while register 2 holds 0 leaves the channel parked and issues no memory access.
- R13: Register 3 reads the address of the last descriptor fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 status, 2 next pointer, 3 current descriptor |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Sticky end-of-chain interrupt |
| mem_rd | output | 1 | Memory read request; data is returned one cycle later |
| mem_wr | output | 1 | Memory write request (status word) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| st_valid | output | 1 | Stream word valid |
| st_data | output | DW | Stream word |
| st_sof | output | 1 | Frame start marker |
| st_eof | output | 1 | Frame end marker |

## Verification
The bench asks for a park just after starting and checks that the whole descriptor still streams. A design that cut the transfer short would lose words, and one that fetched the next descriptor would leave a wrong value in register 2. It cancels a park with a second activate, and it writes the next pointer while the channel is running. A design that took the late write would jump to the wrong chain. It also covers a zero-length descriptor, activate on a zero pointer and a reload after the chain has ended, where a design would hang, emit spurious words or fail to pick up the appended descriptor.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [2:0] {
    CH_IDLE,
    CH_FETCH,
    CH_XFER,
    CH_WBACK,
    CH_STOP,
    CH_LINK
  } ch_state_t;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_NEXT = 2'd2;
  localparam logic [1:0] RA_CUR  = 2'd3;

  localparam int B_ACT  = 0;
  localparam int B_DIS  = 1;
  localparam int B_RLD  = 2;
  localparam int B_IRQ  = 1;

  localparam int DESC_WORDS = 4;
  localparam int SOF_BIT    = 31;
  localparam int EOF_BIT    = 30;
endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          safe,
  input  logic          dis_pend,
  input  logic [AW-1:0] next_ptr,
  input  logic [AW-1:0] cur_ptr,
  input  logic          irq_set,
  output logic          act_p,
  output logic          dis_p,
  output logic          rld_p,
  output logic          nxt_wr,
  output logic [AW-1:0] nxt_wdata,
  output logic          irq
);
  logic irq_d, irq_clr;

  assign act_p     = reg_we && reg_addr == RA_CTRL && reg_wdata[B_ACT];
  assign dis_p     = reg_we && reg_addr == RA_CTRL && reg_wdata[B_DIS];
  assign rld_p     = reg_we && reg_addr == RA_CTRL && reg_wdata[B_RLD];
  assign irq_clr   = reg_we && reg_addr == RA_STAT && reg_wdata[B_IRQ];
  assign nxt_wr    = reg_we && reg_addr == RA_NEXT;
  assign nxt_wdata = reg_wdata[AW-1:0];

  always_comb begin
    irq_d = irq;
    if (irq_clr) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STAT: reg_rdata[2:0] = {dis_pend, irq, safe};
      RA_NEXT: reg_rdata[AW-1:0] = next_ptr;
      RA_CUR:  reg_rdata[AW-1:0] = cur_ptr;
      default: reg_rdata = '0;
    endcase
  end

  // R5: a set request always leaves the interrupt raised
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);
  // R5: only a clear write lowers it
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
  import lldma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter bit HAS_RELOAD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_p,
  input  logic          dis_p,
  input  logic          rld_p,
  input  logic          nxt_wr,
  input  logic [AW-1:0] nxt_wdata,
  output logic          safe,
  output logic          dis_pend,
  output logic [AW-1:0] next_ptr,
  output logic [AW-1:0] cur_ptr,
  output logic          irq_set,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          st_valid,
  output logic [DW-1:0] st_data,
  output logic          st_sof,
  output logic          st_eof
);
  localparam int HW = DESC_WORDS - 1;   // words fetched per descriptor
  localparam logic [LW-1:0] FETCH_END = LW'(HW);

  ch_state_t     st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d, len_q, len_d;
  logic [AW-1:0] nxt_q, nxt_d, cur_q, cur_d, dat_q, dat_d;
  logic          sof_q, sof_d, eof_q, eof_d, dis_q, dis_d, rld_q, rld_d;
  logic          rld_ok;

  generate
    if (HAS_RELOAD) begin : g_rld
      assign rld_ok = rld_p;
    end else begin : g_norld
      assign rld_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; len_d = len_q; nxt_d = nxt_q;
    cur_d = cur_q; dat_d = dat_q; sof_d = sof_q; eof_d = eof_q;
    dis_d = dis_q; rld_d = rld_q;
    mem_rd = 1'b0; mem_wr = 1'b0; mem_addr = '0; mem_wdata = '0;
    irq_set = 1'b0;

    if (st_q != CH_IDLE) begin
      if (dis_p) dis_d = 1'b1;
      if (rld_ok) rld_d = 1'b1;
    end
    if (act_p) dis_d = 1'b0;

    case (st_q)
      CH_IDLE: begin
        if (nxt_wr) nxt_d = nxt_wdata;
        if (act_p && nxt_q != '0) begin
          st_d = CH_FETCH; cur_d = nxt_q; cnt_d = '0;
        end else if (rld_ok) begin
          st_d = CH_LINK; cnt_d = '0;
        end
      end
      CH_FETCH: begin
        if (cnt_q < FETCH_END) begin
          mem_rd   = 1'b1;
          mem_addr = cur_q + AW'(cnt_q);
        end
        if (cnt_q == LW'(1)) nxt_d = mem_rdata[AW-1:0];
        if (cnt_q == LW'(2)) dat_d = mem_rdata[AW-1:0];
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == FETCH_END) begin
          sof_d = mem_rdata[SOF_BIT];
          eof_d = mem_rdata[EOF_BIT];
          len_d = mem_rdata[LW-1:0];
          cnt_d = '0;
          st_d  = CH_XFER;
        end
      end
      CH_XFER: begin
        if (cnt_q < len_q) begin
          mem_rd   = 1'b1;
          mem_addr = dat_q + AW'(cnt_q);
        end
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == len_q) st_d = CH_WBACK;
      end
      CH_WBACK: begin
        mem_wr    = 1'b1;
        mem_addr  = cur_q + AW'(HW);
        mem_wdata = {1'b1, {(DW-1-LW){1'b0}}, len_q};
        cnt_d     = '0;
        if (dis_d) begin
          st_d = CH_STOP;
        end else if (nxt_q == '0) begin
          if (rld_d) begin
            st_d = CH_LINK; rld_d = 1'b0;
          end else begin
            st_d = CH_STOP; irq_set = 1'b1;
          end
        end else begin
          st_d = CH_FETCH; cur_d = nxt_q;
        end
      end
      CH_STOP: begin
        dis_d = 1'b0; rld_d = 1'b0;
        if (act_p && nxt_q != '0) begin
          st_d = CH_FETCH; cur_d = nxt_q; cnt_d = '0;
        end else begin
          st_d = CH_IDLE;
        end
      end
      CH_LINK: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == '0) begin
          mem_rd = 1'b1; mem_addr = cur_q;
        end else begin
          nxt_d = mem_rdata[AW-1:0];
          cnt_d = '0;
          if (mem_rdata[AW-1:0] != '0) begin
            st_d = CH_FETCH; cur_d = mem_rdata[AW-1:0];
          end else begin
            st_d = CH_IDLE;
          end
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CH_IDLE; cnt_q <= '0; len_q <= '0; nxt_q <= '0;
      cur_q <= '0; dat_q <= '0; sof_q <= 1'b0; eof_q <= 1'b0;
      dis_q <= 1'b0; rld_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; len_q <= len_d; nxt_q <= nxt_d;
      cur_q <= cur_d; dat_q <= dat_d; sof_q <= sof_d; eof_q <= eof_d;
      dis_q <= dis_d; rld_q <= rld_d;
    end
  end

  assign safe     = st_q == CH_IDLE;
  assign dis_pend = dis_q;
  assign next_ptr = nxt_q;
  assign cur_ptr  = cur_q;
  assign st_valid = st_q == CH_XFER && cnt_q != '0;
  assign st_data  = mem_rdata;
  assign st_sof   = st_valid && sof_q && cnt_q == LW'(1);
  assign st_eof   = st_valid && eof_q && cnt_q == len_q;

  // R12: a parked channel touches no memory
  a_r12_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    safe |-> !mem_rd && !mem_wr);
  // R12: activate on a zero pointer keeps the channel parked
  a_r12_null_act: assert property (@(posedge clk) disable iff (!rst_n)
    act_p && safe && next_ptr == '0 && !rld_p |=> safe);
  // R9: pointer writes during a transfer are dropped
  a_r9_next_locked: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_wr && st_q == CH_XFER |=> $stable(next_ptr));
  // R3: frame end is followed by the status write, not by data
  a_r3_eof_last: assert property (@(posedge clk) disable iff (!rst_n)
    st_eof |=> !st_valid && mem_wr);
  // R4: status write lasts exactly one cycle
  a_r4_one_wback: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R6: no disable request survives into the parked state
  a_r6_park_clean: assert property (@(posedge clk) disable iff (!rst_n)
    safe |-> !dis_pend);
endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter bit HAS_RELOAD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          st_valid,
  output logic [DW-1:0] st_data,
  output logic          st_sof,
  output logic          st_eof
);
  logic [1:0]    rs_q;
  logic          srst_n;
  logic          safe, dis_pend, irq_set, act_p, dis_p, rld_p, nxt_wr;
  logic [AW-1:0] next_ptr, cur_ptr, nxt_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  lldma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(srst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .safe(safe),
    .dis_pend(dis_pend), .next_ptr(next_ptr), .cur_ptr(cur_ptr),
    .irq_set(irq_set), .act_p(act_p), .dis_p(dis_p), .rld_p(rld_p),
    .nxt_wr(nxt_wr), .nxt_wdata(nxt_wdata), .irq(irq)
  );

  lldma_walker #(.AW(AW), .DW(DW), .LW(LW), .HAS_RELOAD(HAS_RELOAD)) u_walk (
    .clk(clk), .rst_n(srst_n), .act_p(act_p), .dis_p(dis_p), .rld_p(rld_p),
    .nxt_wr(nxt_wr), .nxt_wdata(nxt_wdata), .safe(safe), .dis_pend(dis_pend),
    .next_ptr(next_ptr), .cur_ptr(cur_ptr), .irq_set(irq_set),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .st_valid(st_valid),
    .st_data(st_data), .st_sof(st_sof), .st_eof(st_eof)
  );
endmodule

// File: tb/test_lldma_chan.sv
`timescale 1ns/1ps
module test_lldma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_rd, mem_wr, st_valid, st_sof, st_eof;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, st_data;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:4095];
  logic [31:0] log_d [0:63];
  logic [1:0]  log_f [0:63];
  int          log_n = 0;
  int          rd_n  = 0;
  int          errs  = 0;
  int          chks  = 0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;

  lldma_chan i_lldma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .st_valid(st_valid),
    .st_data(st_data), .st_sof(st_sof), .st_eof(st_eof)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (st_valid && log_n < 64) begin
      log_d[log_n] = st_data;
      log_f[log_n] = {st_sof, st_eof};
      log_n = log_n + 1;
    end
    if (mem_rd) rd_n = rd_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic desc(input int a, input int link, input int dat, input bit s, input bit e, input int n);
    mem[a]   = link;
    mem[a+1] = dat;
    mem[a+2] = {s, e, 14'd0, 16'(n)};
    mem[a+3] = '0;
    for (int i = 0; i < n; i++) mem[dat+i] = 32'hD000_0000 | (dat + i);
  endtask

  task automatic wait_park();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rd(2'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic chk_seg(input string tag, input int off, input int dat, input int n, input bit s, input bit e);
    for (int i = 0; i < n; i++) begin
      chk(log_d[off+i] == (32'hD000_0000 | (dat + i)), tag, log_d[off+i], 32'hD000_0000 | (dat + i));
      chk(log_f[off+i] == {s && i == 0, e && i == n-1}, tag, 32'(log_f[off+i]), 32'({s && i == 0, e && i == n-1}));
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd1, v); chk(v == 32'd1, "R1 status", v, 1);
    rd(2'd2, v); chk(v == 32'd0, "R1 next", v, 0);
    chk(!irq && !st_valid, "R1 outputs", {irq, st_valid}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    desc(16'h100, 16'h110, 16'h200, 1, 0, 3);
    desc(16'h110, 0, 16'h300, 0, 1, 2);
    log_n = 0;
    wr(2'd2, 32'h100);
    wr(2'd0, 32'h1);
    wait_park();
    chk(log_n == 5, "R2 word count", log_n, 5);
    chk_seg("R2 R3 first desc", 0, 16'h200, 3, 1, 0);
    chk_seg("R2 R3 second desc", 3, 16'h300, 2, 0, 1);
    chk(mem[16'h103] == 32'h8000_0003, "R4 status a", mem[16'h103], 32'h8000_0003);
    chk(mem[16'h113] == 32'h8000_0002, "R4 status b", mem[16'h113], 32'h8000_0002);
    chk(irq, "R5 irq set", irq, 1);
    rd(2'd3, v); chk(v == 32'h110, "R13 current", v, 32'h110);
    repeat (3) @(negedge clk);
    chk(irq, "R5 irq sticky", irq, 1);
    wr(2'd1, 32'h2);
    chk(!irq, "R5 irq cleared", irq, 0);
  endtask

  task automatic t_zero();
    desc(16'h120, 0, 16'h380, 1, 1, 0);
    log_n = 0;
    wr(2'd2, 32'h120);
    wr(2'd0, 32'h1);
    wait_park();
    chk(log_n == 0, "R11 no words", log_n, 0);
    chk(mem[16'h123] == 32'h8000_0000, "R11 status", mem[16'h123], 32'h8000_0000);
    wr(2'd1, 32'h2);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    desc(16'h140, 16'h150, 16'h400, 1, 0, 4);
    desc(16'h150, 16'h160, 16'h500, 0, 0, 4);
    desc(16'h160, 0, 16'h600, 0, 1, 4);
    log_n = 0;
    wr(2'd2, 32'h140);
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h2);
    wait_park();
    chk(log_n == 4, "R6 full desc", log_n, 4);
    chk_seg("R6 data", 0, 16'h400, 4, 1, 0);
    chk(!irq, "R6 no irq", irq, 0);
    rd(2'd2, v); chk(v == 32'h150, "R6 next held", v, 32'h150);
    chk(mem[16'h153] == 0, "R6 not fetched", mem[16'h153], 0);
    wr(2'd2, 32'h160);
    log_n = 0;
    wr(2'd0, 32'h1);
    wait_park();
    chk(log_n == 4, "R8 redirect count", log_n, 4);
    chk_seg("R8 redirect data", 0, 16'h600, 4, 0, 1);
    chk(mem[16'h153] == 0, "R8 skipped untouched", mem[16'h153], 0);
    chk(irq, "R8 end irq", irq, 1);
    wr(2'd1, 32'h2);
  endtask

  task automatic t_cancel();
    desc(16'h170, 16'h180, 16'h700, 1, 0, 4);
    desc(16'h180, 0, 16'h780, 0, 1, 3);
    log_n = 0;
    wr(2'd2, 32'h170);
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h2);
    wr(2'd0, 32'h1);
    wait_park();
    chk(log_n == 7, "R7 chain completes", log_n, 7);
    chk_seg("R7 tail data", 4, 16'h780, 3, 0, 1);
    chk(irq, "R7 irq", irq, 1);
    wr(2'd1, 32'h2);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    desc(16'h190, 0, 16'h800, 1, 1, 8);
    desc(16'h1A0, 0, 16'h880, 1, 1, 2);
    log_n = 0;
    wr(2'd2, 32'h190);
    wr(2'd0, 32'h1);
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h1A0);
    wait_park();
    rd(2'd2, v); chk(v == 32'h0, "R9 write ignored", v, 0);
    chk(log_n == 8, "R9 words", log_n, 8);
    chk(mem[16'h1A3] == 0, "R9 no jump", mem[16'h1A3], 0);
    wr(2'd1, 32'h2);
  endtask

  task automatic t_null();
    logic [31:0] v;
    int r0;
    r0 = rd_n;
    wr(2'd0, 32'h1);
    repeat (4) @(negedge clk);
    rd(2'd1, v);
    chk(v == 32'd1, "R12 parked", v, 1);
    chk(rd_n == r0, "R12 no reads", rd_n, r0);
  endtask

  task automatic t_reload();
    desc(16'h1B0, 0, 16'h900, 1, 0, 2);
    log_n = 0;
    wr(2'd2, 32'h1B0);
    wr(2'd0, 32'h1);
    wait_park();
    wr(2'd1, 32'h2);
    desc(16'h1C0, 0, 16'h980, 0, 1, 2);
    mem[16'h1B0] = 32'h1C0;
    wr(2'd0, 32'h4);
    wait_park();
    chk(log_n == 4, "R10 appended words", log_n, 4);
    chk_seg("R10 appended data", 2, 16'h980, 2, 0, 1);
    chk(mem[16'h1C3] == 32'h8000_0002, "R10 status", mem[16'h1C3], 32'h8000_0002);
    chk(irq, "R10 irq", irq, 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_chain();
    t_zero();
    t_disable();
    t_cancel();
    t_locked();
    t_null();
    t_reload();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++; chks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule